// File: doc/BRIEF.md
# Capture/Reload Timer with Up/Down Count and Clock Output

This block is a 16-bit timer/counter paired with a 16-bit capture/reload register and an external trigger input. It advances on a machine-cycle tick. It either counts every tick, or counts falling edges seen on an external count pin. The control settings pick one of four behaviours:

- capture of the running count on a trigger edge;
- automatic reload on overflow, counting up only or up/down with the direction taken from the trigger pin;
- serial baud-rate generation;
- a 50% duty clock output that toggles on every rollover.

Software reaches the block through a byte-wide register port. Writes take effect on the clock edge of the write. Reads return on the clock after the select is presented. A serial block can take a one-clock pulse on each rollover while a baud-clock enable is set.

Top module: `cap_reload_timer`

## Requirements
- R1: Reset clears the count, the reload pair, the control and mode registers, both flags, `clk_out`, `baud_pulse` and `rd_data`. Register selects are: 0 control, 1 mode, 2 count low, 3 count high, 4 reload low, 5 reload high; other selects read 0. `rd_data` shows the selected register one clock after `rd_sel` is applied.
- R2: Control bit 2 enables counting and bit 1 picks the source. With bit 1 at 0 the count advances once per `tick`. With bit 1 at 1 it advances only on a tick where `cnt_pin` is low and was sampled high at the previous tick. The count holds between ticks.
- R3: In auto-reload mode (control bit 0 = 0, no baud or clock-out mode, mode bit 0 = 0), a step from FFFFh loads the reload pair into the count and sets the overflow flag (control bit 7).
- R4: In that same up-only auto-reload mode, with control bit 3 set, a trigger falling edge loads the reload pair into the count and sets the external flag (control bit 6).
- R5: In capture mode (control bit 0 = 1), with control bit 3 set, a trigger falling edge copies the pre-step count into the reload pair and sets the external flag. Counting continues. An overflow in this mode rolls to 0000h and sets the overflow flag.
- R6: With mode bit 0 set (outside capture, baud and clock-out modes), a high trigger pin counts up and a low one counts down. Counting down, a step from a count equal to the reload pair loads FFFFh. Every rollover in this mode sets the overflow flag and toggles the external flag. Trigger edges cause no reload.
- R7: Control bit 5 or bit 4 selects baud mode. In baud mode the count reloads on overflow and the overflow flag stays clear. `baud_pulse` is high for one clock per rollover. A trigger edge with bit 3 set sets the external flag without reloading.
- R8: Mode bit 1 set with control bit 1 clear (and no baud mode) gives clock-out mode. The count reloads on overflow, `clk_out` toggles on each rollover, and the overflow flag stays clear.
- R9: A trigger or count-pin edge is seen only when the pin is sampled 1 at one tick and 0 at the next. A low pulse wholly between ticks is ignored.
- R10: A control-register write sets both flags to the written bits 7 and 6, and it wins over any hardware update in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Machine-cycle enable |
| cnt_pin | input | 1 | External count input |
| trig_pin | input | 1 | Trigger / direction input |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register written |
| wr_data | input | 8 | Write data |
| rd_sel | input | 3 | Register read |
| rd_data | output | 8 | Registered read data |
| ovf_flag | output | 1 | Overflow flag |
| ext_flag | output | 1 | External-event flag |
| baud_pulse | output | 1 | One-clock rollover pulse in baud mode |
| clk_out | output | 1 | Toggling clock output |

## Verification
A wrong count or reload value stays hidden until a rollover or a read. The bench therefore reads the registers back through the port and compares every output against a behavioural model on every clock. A bad step decode shows on the next tick, and a bad reload shows one tick after the rollover, as a flag or count mismatch. Mode-decode errors show at once as a spurious overflow flag, a missing `baud_pulse`, or a `clk_out` that fails to toggle at the rollover tick.

// File: rtl/t2_pkg.sv
package t2_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    SEL_CTRL   = 3'd0,
    SEL_MODE   = 3'd1,
    SEL_CNT_LO = 3'd2,
    SEL_CNT_HI = 3'd3,
    SEL_RLD_LO = 3'd4,
    SEL_RLD_HI = 3'd5
  } reg_sel_e;

  // control bits below the two flags
  typedef struct packed {
    logic rx_baud;
    logic tx_baud;
    logic ext_en;
    logic run;
    logic ct_ext;
    logic cap_sel;
  } ctrl_t;

  typedef struct packed {
    logic out_en;
    logic dn_en;
  } mode_t;
endpackage

// File: rtl/t2_pin_sampler.sv
module t2_pin_sampler #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [N-1:0] pins,
  output logic [N-1:0] falls
);
  logic [N-1:0] seen_q;

  for (genvar i = 0; i < N; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst)       seen_q[i] <= 1'b0;
      else if (tick) seen_q[i] <= pins[i];
    end
    assign falls[i] = tick & seen_q[i] & ~pins[i];
  end
endmodule

// File: rtl/t2_count_core.sv
module t2_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic             ct_ext,
  input  logic             cnt_fall,
  input  logic             trig_fall,
  input  logic             trig_lvl,
  input  logic             cap_sel,
  input  logic             ext_en,
  input  logic             dn_en,
  input  logic             baud,
  input  logic             clko,
  input  logic             wr_ctrl,
  input  logic             wr_ovf,
  input  logic             wr_ext,
  input  logic [3:0]       wr_byte_en,
  input  logic [7:0]       wr_byte,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] rld_q,
  output logic             ovf_q,
  output logic             ext_q,
  output logic             baud_q,
  output logic             clko_q
);
  localparam int BW   = t2_pkg::BYTE_W;
  localparam int HI_W = CNT_W - BW;

  logic quiet, capture, updown, step, down, roll, edge_hit;
  logic [CNT_W-1:0] cnt_nxt, rld_nxt;
  logic ovf_nxt, ext_nxt;

  always_comb begin
    quiet    = baud | clko;
    capture  = cap_sel & ~quiet;
    updown   = dn_en & ~capture & ~quiet;
    step     = tick & run & (ct_ext ? cnt_fall : 1'b1);
    down     = updown & ~trig_lvl;
    roll     = step & (down ? (cnt_q == rld_q) : (&cnt_q));
    edge_hit = trig_fall & ext_en & ~updown;

    cnt_nxt = cnt_q;
    if (edge_hit & ~capture & ~quiet) cnt_nxt = rld_q;
    else if (step) begin
      if (down)      cnt_nxt = roll ? '1 : cnt_q - 1'b1;
      else if (roll) cnt_nxt = capture ? '0 : rld_q;
      else           cnt_nxt = cnt_q + 1'b1;
    end
    if (wr_byte_en[0]) cnt_nxt[BW-1:0]    = wr_byte;
    if (wr_byte_en[1]) cnt_nxt[CNT_W-1:BW] = wr_byte[HI_W-1:0];

    rld_nxt = (edge_hit & capture) ? cnt_q : rld_q;
    if (wr_byte_en[2]) rld_nxt[BW-1:0]    = wr_byte;
    if (wr_byte_en[3]) rld_nxt[CNT_W-1:BW] = wr_byte[HI_W-1:0];

    if (wr_ctrl) begin
      ovf_nxt = wr_ovf;
      ext_nxt = wr_ext;
    end else begin
      ovf_nxt = ovf_q | (roll & ~quiet);
      if (edge_hit)            ext_nxt = 1'b1;
      else if (updown & roll)  ext_nxt = ~ext_q;
      else                     ext_nxt = ext_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      rld_q  <= '0;
      ovf_q  <= 1'b0;
      ext_q  <= 1'b0;
      baud_q <= 1'b0;
      clko_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      rld_q  <= rld_nxt;
      ovf_q  <= ovf_nxt;
      ext_q  <= ext_nxt;
      baud_q <= roll & baud;
      clko_q <= clko_q ^ (roll & clko);
    end
  end
endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer #(
  parameter int CNT_W = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       cnt_pin,
  input  logic       trig_pin,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_sel,
  output logic [7:0] rd_data,
  output logic       ovf_flag,
  output logic       ext_flag,
  output logic       baud_pulse,
  output logic       clk_out
);
  import t2_pkg::*;
  localparam int BW   = BYTE_W;
  localparam int HI_W = CNT_W - BW;

  ctrl_t ctrl_q;
  mode_t mode_q;
  logic [CNT_W-1:0] cnt_w, rld_w;
  logic [1:0] falls_w;
  logic baud_w, clko_w, quiet_w;
  logic [3:0] byte_en_w;
  logic wr_ctrl_w;

  assign wr_ctrl_w = wr_en & (wr_sel == SEL_CTRL);
  assign byte_en_w = {wr_en & (wr_sel == SEL_RLD_HI), wr_en & (wr_sel == SEL_RLD_LO),
                      wr_en & (wr_sel == SEL_CNT_HI), wr_en & (wr_sel == SEL_CNT_LO)};
  assign baud_w  = ctrl_q.rx_baud | ctrl_q.tx_baud;
  assign clko_w  = mode_q.out_en & ~ctrl_q.ct_ext & ~baud_w;
  assign quiet_w = baud_w | clko_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      mode_q <= '0;
    end else if (wr_en) begin
      if (wr_sel == SEL_CTRL) ctrl_q <= wr_data[5:0];
      if (wr_sel == SEL_MODE) mode_q <= wr_data[1:0];
    end
  end

  t2_pin_sampler #(.N(2)) sampler_i (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .pins  ({trig_pin, cnt_pin}),
    .falls (falls_w)
  );

  t2_count_core #(.CNT_W(CNT_W)) core_i (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .run        (ctrl_q.run),
    .ct_ext     (ctrl_q.ct_ext),
    .cnt_fall   (falls_w[0]),
    .trig_fall  (falls_w[1]),
    .trig_lvl   (trig_pin),
    .cap_sel    (ctrl_q.cap_sel),
    .ext_en     (ctrl_q.ext_en),
    .dn_en      (mode_q.dn_en),
    .baud       (baud_w),
    .clko       (clko_w),
    .wr_ctrl    (wr_ctrl_w),
    .wr_ovf     (wr_data[7]),
    .wr_ext     (wr_data[6]),
    .wr_byte_en (byte_en_w),
    .wr_byte    (wr_data),
    .cnt_q      (cnt_w),
    .rld_q      (rld_w),
    .ovf_q      (ovf_flag),
    .ext_q      (ext_flag),
    .baud_q     (baud_pulse),
    .clko_q     (clk_out)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (rd_sel)
        SEL_CTRL:   rd_data <= {ovf_flag, ext_flag, ctrl_q};
        SEL_MODE:   rd_data <= {6'b0, mode_q};
        SEL_CNT_LO: rd_data <= cnt_w[BW-1:0];
        SEL_CNT_HI: rd_data <= {{(8-HI_W){1'b0}}, cnt_w[CNT_W-1:BW]};
        SEL_RLD_LO: rd_data <= rld_w[BW-1:0];
        SEL_RLD_HI: rd_data <= {{(8-HI_W){1'b0}}, rld_w[CNT_W-1:BW]};
        default:    rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/cap_reload_timer_chk.sv
module cap_reload_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             wr_en,
  input logic             ovf_flag,
  input logic             ext_flag,
  input logic             baud_pulse,
  input logic             clk_out,
  input logic             quiet_w,
  input logic [CNT_W-1:0] cnt_w
);
  // R3: the overflow flag rises only from a tick or a control write
  p_ovf_source_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_flag) |-> ($past(tick) || $past(wr_en)));

  // R7: in baud or clock-out mode a rollover never raises the flag
  p_quiet_no_ovf_r7: assert property (@(posedge clk) disable iff (rst)
    ($rose(ovf_flag) && !$past(wr_en)) |-> !$past(quiet_w));

  // R7: rollover pulse comes only from a tick
  p_baud_tick_r7: assert property (@(posedge clk) disable iff (rst)
    baud_pulse |-> $past(tick));

  // R8: clock output changes only on a tick
  p_clko_tick_r8: assert property (@(posedge clk) disable iff (rst)
    (clk_out != $past(clk_out)) |-> $past(tick));

  // R2: the count holds when there is neither a tick nor a write
  p_count_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(tick) && !$past(wr_en)) |-> $stable(cnt_w));

  // R4: the external flag changes only on a tick or a write
  p_ext_source_r4: assert property (@(posedge clk) disable iff (rst)
    (ext_flag != $past(ext_flag)) |-> ($past(tick) || $past(wr_en)));
endmodule

bind cap_reload_timer cap_reload_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .tick       (tick),
  .wr_en      (wr_en),
  .ovf_flag   (ovf_flag),
  .ext_flag   (ext_flag),
  .baud_pulse (baud_pulse),
  .clk_out    (clk_out),
  .quiet_w    (quiet_w),
  .cnt_w      (cnt_w)
);

// File: tb/cap_reload_timer_tb_top.sv
module cap_reload_timer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, cnt_pin = 1'b0, trig_pin = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_sel = '0, rd_sel = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic ovf_flag, ext_flag, baud_pulse, clk_out;

  int checks = 0, failures = 0;
  int baud_seen = 0, clko_toggles = 0;
  logic prev_clko = 1'b0;
  logic [7:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  cap_reload_timer dut_i (
    .clk(clk), .rst(rst), .tick(tick), .cnt_pin(cnt_pin), .trig_pin(trig_pin),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .ovf_flag(ovf_flag), .ext_flag(ext_flag),
    .baud_pulse(baud_pulse), .clk_out(clk_out)
  );

  // behavioural reference model
  logic [15:0] m_cnt, m_rld;
  logic [7:0]  m_ctrl, m_rd;
  logic [1:0]  m_mode;
  logic m_tq, m_cq, m_baud, m_clko;

  always @(posedge clk) begin
    logic bd, co, qt, cap, ud, tf, cf, st, dn, rl, eh;
    logic [15:0] nc, nr;
    logic [7:0] nctl;
    if (rst) begin
      m_cnt = 0; m_rld = 0; m_ctrl = 0; m_rd = 0; m_mode = 0;
      m_tq = 0; m_cq = 0; m_baud = 0; m_clko = 0;
    end else begin
      case (rd_sel)
        3'd0: m_rd = m_ctrl;
        3'd1: m_rd = {6'b0, m_mode};
        3'd2: m_rd = m_cnt[7:0];
        3'd3: m_rd = m_cnt[15:8];
        3'd4: m_rd = m_rld[7:0];
        3'd5: m_rd = m_rld[15:8];
        default: m_rd = 0;
      endcase
      bd  = m_ctrl[5] | m_ctrl[4];
      co  = m_mode[1] & ~m_ctrl[1] & ~bd;
      qt  = bd | co;
      cap = m_ctrl[0] & ~qt;
      ud  = m_mode[0] & ~cap & ~qt;
      tf  = tick & m_tq & ~trig_pin;
      cf  = tick & m_cq & ~cnt_pin;
      st  = tick & m_ctrl[2] & (m_ctrl[1] ? cf : 1'b1);
      dn  = ud & ~trig_pin;
      rl  = st & (dn ? (m_cnt == m_rld) : (m_cnt == 16'hFFFF));
      eh  = tf & m_ctrl[3] & ~ud;
      nc = m_cnt; nr = m_rld; nctl = m_ctrl;
      if (eh && !cap && !qt) nc = m_rld;
      else if (st) begin
        if (dn) nc = rl ? 16'hFFFF : m_cnt - 16'd1;
        else if (rl) nc = cap ? 16'h0000 : m_rld;
        else nc = m_cnt + 16'd1;
      end
      if (eh && cap) nr = m_cnt;
      if (rl && !qt) nctl[7] = 1'b1;
      if (eh) nctl[6] = 1'b1;
      else if (ud && rl) nctl[6] = ~m_ctrl[6];
      if (wr_en) begin
        case (wr_sel)
          3'd0: nctl = wr_data;
          3'd1: m_mode = wr_data[1:0];
          3'd2: nc[7:0] = wr_data;
          3'd3: nc[15:8] = wr_data;
          3'd4: nr[7:0] = wr_data;
          3'd5: nr[15:8] = wr_data;
          default: ;
        endcase
      end
      m_baud = rl & bd;
      if (rl && co) m_clko = ~m_clko;
      if (tick) begin m_tq = trig_pin; m_cq = cnt_pin; end
      m_cnt = nc; m_rld = nr; m_ctrl = nctl;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (ovf_flag !== m_ctrl[7]) begin failures++; $display("FAIL R3 ovf_flag act=%b exp=%b t=%0t", ovf_flag, m_ctrl[7], $time); end
      if (ext_flag !== m_ctrl[6]) begin failures++; $display("FAIL R4 ext_flag act=%b exp=%b t=%0t", ext_flag, m_ctrl[6], $time); end
      if (baud_pulse !== m_baud)  begin failures++; $display("FAIL R7 baud_pulse act=%b exp=%b t=%0t", baud_pulse, m_baud, $time); end
      if (clk_out !== m_clko)     begin failures++; $display("FAIL R8 clk_out act=%b exp=%b t=%0t", clk_out, m_clko, $time); end
      if (rd_data !== m_rd)       begin failures++; $display("FAIL R1 rd_data act=%h exp=%h t=%0t", rd_data, m_rd, $time); end
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [7:0] v);
    @(negedge clk); rd_sel = s;
    @(negedge clk); v = rd_data;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    if (baud_pulse) baud_seen++;
    if (clk_out != prev_clko) clko_toggles++;
    prev_clko = clk_out;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state and readback
    for (int s = 0; s < 6; s++) begin
      rd(3'(s), rv); check("R1 reset read", {8'h0, rv}, 16'h0);
    end
    check("R1 reset outputs", {12'h0, ovf_flag, ext_flag, baud_pulse, clk_out}, 16'h0);
    wr(3'd2, 8'h34); wr(3'd3, 8'h12);
    rd(3'd2, rv); check("R1 count low", {8'h0, rv}, 16'h0034);
    rd(3'd3, rv); check("R1 count high", {8'h0, rv}, 16'h0012);

    // R2 timer counts ticks
    wr(3'd0, 8'h04);
    for (int i = 0; i < 5; i++) do_tick();
    idle(3);
    rd(3'd2, rv); check("R2 timer steps", {8'h0, rv}, 16'h0039);

    // R3 overflow reload
    wr(3'd3, 8'hFF); wr(3'd2, 8'hFE); wr(3'd4, 8'h10); wr(3'd5, 8'hAB);
    do_tick(); do_tick();
    rd(3'd2, rv); check("R3 reload low", {8'h0, rv}, 16'h0010);
    rd(3'd3, rv); check("R3 reload high", {8'h0, rv}, 16'h00AB);
    check("R3 ovf set", {15'h0, ovf_flag}, 16'h1);
    // R10 control write clears flag
    wr(3'd0, 8'h04);
    check("R10 flag cleared", {15'h0, ovf_flag}, 16'h0);

    // R4 trigger reload, R9 pulse between ticks ignored
    wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd0, 8'h0C);
    trig_pin = 1'b1; do_tick();
    @(negedge clk); trig_pin = 1'b0; idle(2); trig_pin = 1'b1;
    do_tick();
    check("R9 no edge between ticks", {15'h0, ext_flag}, 16'h0);
    rd(3'd2, rv); check("R9 count after ignored pulse", {8'h0, rv}, 16'h0002);
    trig_pin = 1'b0; do_tick();
    check("R4 ext set", {15'h0, ext_flag}, 16'h1);
    rd(3'd2, rv); check("R4 reload on edge", {8'h0, rv}, 16'h0010);

    // R5 capture
    wr(3'd0, 8'h0D); wr(3'd2, 8'h00); wr(3'd3, 8'h01);
    trig_pin = 1'b1; do_tick();
    trig_pin = 1'b0; do_tick();
    check("R5 ext set", {15'h0, ext_flag}, 16'h1);
    rd(3'd4, rv); check("R5 captured low", {8'h0, rv}, 16'h0001);
    rd(3'd5, rv); check("R5 captured high", {8'h0, rv}, 16'h0001);
    rd(3'd2, rv); check("R5 count continues", {8'h0, rv}, 16'h0002);
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); do_tick();
    rd(3'd3, rv); check("R5 roll to zero", {8'h0, rv}, 16'h0000);
    check("R5 ovf set", {15'h0, ovf_flag}, 16'h1);

    // R6 up/down
    wr(3'd1, 8'h01); wr(3'd0, 8'h04);
    wr(3'd4, 8'h05); wr(3'd5, 8'h00); wr(3'd2, 8'h07); wr(3'd3, 8'h00);
    do_tick(); do_tick(); do_tick();
    rd(3'd2, rv); check("R6 underflow loads ones", {8'h0, rv}, 16'h00FF);
    check("R6 ext toggled", {14'h0, ovf_flag, ext_flag}, 16'h3);
    trig_pin = 1'b1; do_tick();
    rd(3'd2, rv); check("R6 up overflow reload", {8'h0, rv}, 16'h0005);
    check("R6 ext toggled back", {15'h0, ext_flag}, 16'h0);

    // R7 baud mode
    wr(3'd1, 8'h00); wr(3'd0, 8'h2C);
    wr(3'd4, 8'hFD); wr(3'd5, 8'hFF); wr(3'd2, 8'hFD); wr(3'd3, 8'hFF);
    baud_seen = 0;
    for (int i = 0; i < 9; i++) do_tick();
    check("R7 pulse count", 16'(baud_seen), 16'd3);
    check("R7 no ovf", {15'h0, ovf_flag}, 16'h0);
    trig_pin = 1'b0; do_tick();
    check("R7 edge sets ext", {15'h0, ext_flag}, 16'h1);
    rd(3'd2, rv); check("R7 no reload on edge", {8'h0, rv}, 16'h00FE);

    // R8 clock out
    wr(3'd1, 8'h02); wr(3'd0, 8'h04);
    wr(3'd4, 8'hFE); wr(3'd2, 8'hFE);
    prev_clko = clk_out; clko_toggles = 0;
    for (int i = 0; i < 4; i++) do_tick();
    check("R8 toggles", 16'(clko_toggles), 16'd2);
    check("R8 no ovf", {15'h0, ovf_flag}, 16'h0);

    // R2 counter function, R9 on count pin
    wr(3'd1, 8'h00); wr(3'd0, 8'h06); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    cnt_pin = 1'b1; do_tick(); cnt_pin = 1'b0; do_tick(); do_tick();
    cnt_pin = 1'b1; do_tick(); cnt_pin = 1'b0; do_tick();
    cnt_pin = 1'b1; idle(1); cnt_pin = 1'b0; do_tick();
    rd(3'd2, rv); check("R2 counts pin falls", {8'h0, rv}, 16'h0002);

    // R10 write sets flags
    wr(3'd0, 8'h84);
    rd(3'd0, rv); check("R10 ctrl readback", {8'h0, rv}, 16'h0084);

    // mixed stimulus against the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      tick = ($urandom_range(0, 2) != 0);
      trig_pin = ($urandom_range(0, 3) == 0) ? ~trig_pin : trig_pin;
      cnt_pin = $urandom_range(0, 1);
      rd_sel = 3'($urandom_range(0, 6));
      wr_en = ($urandom_range(0, 15) == 0);
      wr_sel = 3'($urandom_range(0, 5));
      wr_data = 8'($urandom_range(0, 255));
      if (wr_sel == 3'd3 || wr_sel == 3'd5) wr_data = 8'hFF;
      if (wr_sel == 3'd1) wr_data = 8'($urandom_range(0, 3));
    end
    @(negedge clk); wr_en = 1'b0; tick = 1'b0;
    idle(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule